// File: doc/BRIEF.md
# Link-Side Transmit Handover Controller

This block runs the link end of the transmit handover on a shared 2-bit control bus and an 8-bit data bus. Once a bus request has gone out, it watches the control bus for the PHY to give up the interface. The PHY signals this with Grant followed by Idle. The controller then owns both buses. It may drive one leading Idle cycle, selected by a parameter. It drives Hold while its packet source has no byte ready. It then streams the packet with the Transmit code, one byte per cycle, and closes with a single terminating cycle followed by one more Idle before it lets go of the buses.

The packet source sees a valid/ready byte handshake. A byte is taken in the cycle where `src_ready` is high. The last byte of a packet carries `src_last`, and `src_concat` asks for the terminating code that keeps the bus for a chained packet. Two cases end the transfer early: the source staying empty past the hold budget, and the source running dry partway through a packet. In both the controller closes with Idle and raises a one-cycle error pulse. All bus outputs and their drive enables come straight from registers.

Top module: `link_tx_handshake`

## Requirements
- R1: After a synchronous reset, `ctl_oe` and `data_oe` are 0, `ctl_out` is 00, `data_out` is 0, `err` is 0, and `src_ready` stays 0 even with `src_valid` high.
- R2: The buses are taken only when `req_pending` is high and `ctl_in` shows Grant (11) in one cycle and Idle (00) in the next. The first owned cycle is the cycle after that Idle. Grant without `req_pending`, or Grant followed by any code other than Idle, starts nothing.
- R3: With `LEAD_IDLE`=1, the first owned cycle drives Idle (00) with `ctl_oe` high. With `LEAD_IDLE`=0, that cycle already carries Hold or Transmit.
- R4: While the source has no byte ready before the first byte, the controller drives Hold (01), for at most `HOLD_MAX` consecutive cycles.
- R5: A byte offered with `src_valid` is taken in the cycle `src_ready` is high. It appears on `data_out` with `ctl_out` = Transmit (10) in the next cycle. Bytes are sent in the order taken.
- R6: The cycle after the last byte drives Hold (01) if that byte carried `src_concat`, and Idle (00) otherwise.
- R7: The terminating cycle is followed by exactly one Idle cycle with the buses still driven. In the cycle after that, both enables are 0.
- R8: The controller ignores `ctl_in` in the first cycle after release, so a Grant in that cycle starts no handover.
- R9: If no byte is ready after `HOLD_MAX` Hold cycles, the next cycle drives Idle with `err` high for that one cycle. One more Idle follows, then release.
- R10: If `src_valid` drops after a byte that is not the last, the next cycle drives Idle with `err` high. One more Idle follows, then release.
- R11: `ctl_oe` and `data_oe` are high together and only in owned cycles. `data_out` is 0 whenever `ctl_out` is not Transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pending | input | 1 | A bus request has been issued and is awaiting handover |
| ctl_in | input | 2 | Control code seen on the shared control bus (Grant 11, Idle 00) |
| ctl_out | output | 2 | Control code driven while owning the bus (00 Idle, 01 Hold, 10 Transmit) |
| ctl_oe | output | 1 | Drive enable for the control bus |
| data_out | output | DATA_W | Byte driven on the data bus |
| data_oe | output | 1 | Drive enable for the data bus |
| src_valid | input | 1 | Packet source offers a byte |
| src_data | input | DATA_W | Offered byte |
| src_last | input | 1 | Offered byte is the last of its packet |
| src_concat | input | 1 | With the last byte: close with Hold to chain another packet |
| src_ready | output | 1 | Offered byte is taken this cycle |
| err | output | 1 | One-cycle pulse on a hold timeout or a mid-packet underrun |

## Verification
The bench builds the block with `LEAD_IDLE`=1, `HOLD_MAX`=47 and `DATA_W`=8. The lead Idle cycle therefore shows up in every transfer. The full 47-cycle hold budget is used once without tripping the limit and once one cycle past it, which reaches the abort path. Random transfers vary the hold length, packet length, payload and chaining choice. Directed cases cover a false Grant, Grant without a request, a Grant in the cycle after release, and a mid-packet underrun.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;
  // Control bus codes; the same two bits carry different meanings per owner
  typedef enum logic [1:0] {
    CTL_IDLE  = 2'b00,
    CTL_HOLD  = 2'b01,
    CTL_XMIT  = 2'b10,
    CTL_GRANT = 2'b11
  } ctl_code_t;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_LEAD,
    ST_HOLD,
    ST_XMIT,
    ST_TERM,
    ST_TAIL,
    ST_REST
  } tx_state_t;
endpackage

// File: rtl/link_tx_handover.sv
module link_tx_handover
  import link_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic [1:0] ctl_in,
  output logic       take
);
  logic saw_grant;

  always_ff @(posedge clk) begin
    if (rst) saw_grant <= 1'b0;
    else     saw_grant <= arm && (ctl_in == CTL_GRANT);
  end

  // Grant in the previous cycle, Idle now: the interface is handed over
  assign take = arm && saw_grant && (ctl_in == CTL_IDLE);
endmodule

// File: rtl/link_tx_hold_timer.sv
module link_tx_hold_timer #(
  parameter int HOLD_MAX = 47
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(HOLD_MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (inc)    cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(HOLD_MAX));
endmodule

// File: rtl/link_tx_bus_reg.sv
module link_tx_bus_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ctl_nxt,
  input  logic              own_nxt,
  input  logic [DATA_W-1:0] data_nxt,
  output logic [1:0]        ctl_out,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_out  <= 2'b00;
      ctl_oe   <= 1'b0;
      data_out <= '0;
      data_oe  <= 1'b0;
    end else begin
      ctl_out  <= own_nxt ? ctl_nxt : 2'b00;
      ctl_oe   <= own_nxt;
      data_out <= own_nxt ? data_nxt : '0;
      data_oe  <= own_nxt;
    end
  end
endmodule

// File: rtl/link_tx_handshake.sv
module link_tx_handshake
  import link_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HOLD_MAX  = 47,
  parameter bit LEAD_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_pending,
  input  logic [1:0]        ctl_in,
  output logic [1:0]        ctl_out,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  input  logic              src_concat,
  output logic              src_ready,
  output logic              err
);
  tx_state_t state, nxt;
  logic take, at_limit, accept, abort, decide, take_decides;
  logic last_q, cat_q, own_nxt;
  logic [1:0] ctl_nxt;
  logic [DATA_W-1:0] data_nxt;

  // The parameter picks whether the handover edge already makes the first byte decision
  generate
    if (LEAD_IDLE) begin : g_lead
      assign take_decides = 1'b0;
    end else begin : g_nolead
      assign take_decides = 1'b1;
    end
  endgenerate

  link_tx_handover u_handover (
    .clk    (clk),
    .rst    (rst),
    .arm    (req_pending && (state == ST_WAIT)),
    .ctl_in (ctl_in),
    .take   (take)
  );

  link_tx_hold_timer #(.HOLD_MAX(HOLD_MAX)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .clr      (nxt != ST_HOLD),
    .inc      (nxt == ST_HOLD),
    .at_limit (at_limit)
  );

  assign decide = (state == ST_LEAD) || ((state == ST_WAIT) && take && take_decides);

  always_comb begin
    nxt    = state;
    accept = 1'b0;
    abort  = 1'b0;
    if (decide) begin
      if (src_valid) begin
        nxt    = ST_XMIT;
        accept = 1'b1;
      end else begin
        nxt = ST_HOLD;
      end
    end else begin
      case (state)
        ST_WAIT: if (take) nxt = ST_LEAD;
        ST_HOLD: begin
          if (src_valid) begin
            nxt    = ST_XMIT;
            accept = 1'b1;
          end else if (at_limit) begin
            nxt   = ST_TERM;
            abort = 1'b1;
          end
        end
        ST_XMIT: begin
          if (last_q) begin
            nxt = ST_TERM;
          end else if (src_valid) begin
            accept = 1'b1;
          end else begin
            nxt   = ST_TERM;
            abort = 1'b1;
          end
        end
        ST_TERM: nxt = ST_TAIL;
        ST_TAIL: nxt = ST_REST;
        ST_REST: nxt = ST_WAIT;
        default: nxt = ST_WAIT;
      endcase
    end
  end

  always_comb begin
    case (nxt)
      ST_HOLD: ctl_nxt = CTL_HOLD;
      ST_XMIT: ctl_nxt = CTL_XMIT;
      ST_TERM: ctl_nxt = ((state == ST_XMIT) && last_q && cat_q) ? CTL_HOLD : CTL_IDLE;
      default: ctl_nxt = CTL_IDLE;
    endcase
  end

  assign own_nxt   = (nxt == ST_LEAD) || (nxt == ST_HOLD) || (nxt == ST_XMIT) ||
                     (nxt == ST_TERM) || (nxt == ST_TAIL);
  assign data_nxt  = accept ? src_data : '0;
  assign src_ready = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_WAIT;
      err    <= 1'b0;
      last_q <= 1'b0;
      cat_q  <= 1'b0;
    end else begin
      state <= nxt;
      err   <= abort;
      if (accept) begin
        last_q <= src_last;
        cat_q  <= src_concat;
      end
    end
  end

  link_tx_bus_reg #(.DATA_W(DATA_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .ctl_nxt  (ctl_nxt),
    .own_nxt  (own_nxt),
    .data_nxt (data_nxt),
    .ctl_out  (ctl_out),
    .ctl_oe   (ctl_oe),
    .data_out (data_out),
    .data_oe  (data_oe)
  );
endmodule

// File: rtl/link_tx_checker.sv
module link_tx_checker
  import link_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HOLD_MAX = 47
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        ctl_in,
  input logic [1:0]        ctl_out,
  input logic              ctl_oe,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              err
);
  localparam int RW = $clog2(HOLD_MAX + 2) + 1;
  logic [RW-1:0] hold_run;

  always_ff @(posedge clk) begin
    if (rst)                               hold_run <= '0;
    else if (ctl_oe && ctl_out == CTL_HOLD) hold_run <= hold_run + 1'b1;
    else                                   hold_run <= '0;
  end

  a_r2_grant_then_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_oe) |-> ($past(ctl_in) == CTL_IDLE) && ($past(ctl_in, 2) == CTL_GRANT));

  a_r4_hold_bound: assert property (@(posedge clk) disable iff (rst)
    hold_run <= RW'(HOLD_MAX));

  a_r7_release_after_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_oe) |-> ($past(ctl_out) == CTL_IDLE) && $past(ctl_oe));

  a_r9_err_on_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> ctl_oe && (ctl_out == CTL_IDLE));

  a_r11_enables_together: assert property (@(posedge clk) disable iff (rst)
    ctl_oe == data_oe);

  a_r11_data_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctl_out != CTL_XMIT) |-> (data_out == '0));

  a_r11_released_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctl_oe |-> (ctl_out == CTL_IDLE) && !err);
endmodule

bind link_tx_handshake link_tx_checker #(.DATA_W(DATA_W), .HOLD_MAX(HOLD_MAX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctl_in   (ctl_in),
  .ctl_out  (ctl_out),
  .ctl_oe   (ctl_oe),
  .data_out (data_out),
  .data_oe  (data_oe),
  .err      (err)
);

// File: tb/tb_link_tx_handshake.sv
`timescale 1ns/1ps
module tb_link_tx_handshake;
  localparam int  DW   = 8;
  localparam int  HMAX = 47;
  localparam bit  LEAD = 1'b1;
  localparam logic [1:0] C_IDLE = 2'b00, C_HOLD = 2'b01, C_XMIT = 2'b10, C_GRANT = 2'b11;

  logic clk = 1'b0, rst = 1'b1;
  logic req_pending = 1'b0;
  logic [1:0] ctl_in = C_IDLE;
  logic [1:0] ctl_out;
  logic ctl_oe, data_oe, src_ready, err;
  logic [DW-1:0] data_out;
  logic src_valid = 1'b0, src_last = 1'b0, src_concat = 1'b0;
  logic [DW-1:0] src_data = '0;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  link_tx_handshake #(.DATA_W(DW), .HOLD_MAX(HMAX), .LEAD_IDLE(LEAD)) dut (
    .clk(clk), .rst(rst), .req_pending(req_pending), .ctl_in(ctl_in),
    .ctl_out(ctl_out), .ctl_oe(ctl_oe), .data_out(data_out), .data_oe(data_oe),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
    .src_concat(src_concat), .src_ready(src_ready), .err(err));

  function automatic logic [1:0] term_code(input bit cat);
    return cat ? C_HOLD : C_IDLE;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_owned(input string req, input logic [1:0] code, input bit e);
    chk(ctl_oe && data_oe, req, "enables", {ctl_oe, data_oe}, 3);
    chk(ctl_out == code, req, "ctl_out", ctl_out, code);
    chk(err == e, req, "err", err, e);
    if (code != C_XMIT) chk(data_out == 0, "R11", "data idle", data_out, 0);
  endtask

  task automatic chk_released(input string req);
    chk(!ctl_oe && !data_oe, req, "enables off", {ctl_oe, data_oe}, 0);
    chk(ctl_out == C_IDLE && data_out == 0, "R11", "quiet bus", {ctl_out, data_out}, 0);
  endtask

  // One decision cycle: offer inputs, check handshake, advance
  task automatic step(input bit v, input logic [DW-1:0] d, input bit l, input bit c, input bit exp_rdy);
    src_valid = v; src_data = d; src_last = l; src_concat = c;
    #1;
    chk(src_ready == exp_rdy, "R5", "src_ready", src_ready, exp_rdy);
    @(negedge clk);
  endtask

  task automatic handover();
    @(negedge clk);
    req_pending = 1'b1; ctl_in = C_GRANT;
    @(negedge clk);
    chk(!ctl_oe, "R2", "not owned before idle", ctl_oe, 0);
    ctl_in = C_IDLE;
    if (LEAD) begin
      @(negedge clk);
      chk_owned("R3", C_IDLE, 1'b0);
    end
  endtask

  task automatic finish_tail(input string req);
    @(negedge clk);
    chk_owned("R7", C_IDLE, 1'b0);
    @(negedge clk);
    chk_released(req);
    req_pending = 1'b0;
  endtask

  task automatic xfer(input int hold, input int nb, input bit cat);
    logic [DW-1:0] b;
    handover();
    for (int h = 0; h < hold; h++) begin
      step(1'b0, '0, 1'b0, 1'b0, 1'b0);
      chk_owned("R4", C_HOLD, 1'b0);
    end
    for (int i = 0; i < nb; i++) begin
      b = DW'($urandom);
      step(1'b1, b, i == nb - 1, cat, 1'b1);
      chk_owned("R5", C_XMIT, 1'b0);
      chk(data_out == b, "R5", "byte", data_out, b);
    end
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk_owned("R6", term_code(cat), 1'b0);
    finish_tail("R7");
  endtask

  initial begin
    void'($urandom(32'h1394_5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    src_valid = 1'b1;
    #1;
    chk(src_ready == 0, "R1", "ready after reset", src_ready, 0);
    chk(err == 0, "R1", "err after reset", err, 0);
    chk_released("R1");
    src_valid = 1'b0;

    // R2: Grant without request, then Grant followed by a non-idle code
    @(negedge clk); ctl_in = C_GRANT;
    @(negedge clk); ctl_in = C_IDLE;
    @(negedge clk); chk_released("R2");
    @(negedge clk); chk_released("R2");
    req_pending = 1'b1; ctl_in = C_GRANT;
    @(negedge clk); ctl_in = C_HOLD;
    @(negedge clk); ctl_in = C_IDLE;
    @(negedge clk); chk_released("R2");
    @(negedge clk); chk_released("R2");
    req_pending = 1'b0;

    // Directed: short packets, chaining both ways, full hold budget
    xfer(0, 1, 1'b0);
    xfer(0, 1, 1'b1);
    xfer(3, 4, 1'b1);
    xfer(HMAX, 2, 1'b0);

    // R8: Grant in the first cycle after release must be ignored
    xfer(1, 2, 1'b0);
    req_pending = 1'b1; ctl_in = C_GRANT;
    @(negedge clk); ctl_in = C_IDLE;
    @(negedge clk); chk_released("R8");
    @(negedge clk); chk_released("R8");
    req_pending = 1'b0;

    // R9: source stays empty one cycle past the hold budget
    handover();
    for (int h = 0; h < HMAX; h++) begin
      step(1'b0, '0, 1'b0, 1'b0, 1'b0);
      chk_owned("R4", C_HOLD, 1'b0);
    end
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk_owned("R9", C_IDLE, 1'b1);
    finish_tail("R9");

    // R10: source runs dry after a non-last byte
    handover();
    step(1'b1, 8'hA5, 1'b0, 1'b0, 1'b1);
    chk_owned("R10", C_XMIT, 1'b0);
    step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b1);
    chk(data_out == 8'h3C, "R10", "byte", data_out, 8'h3C);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk_owned("R10", C_IDLE, 1'b1);
    finish_tail("R10");

    // Random transfers
    for (int n = 0; n < 40; n++) begin
      xfer(int'($urandom_range(0, 12)), int'($urandom_range(1, 10)), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule